// File: doc/BRIEF.md
# Shared-Pin Port Controller

This block runs an eight-pin parallel port. Each pin can be handed to a synchronous serial peripheral or kept as a general-purpose I/O line. Software reaches the port through two 16-bit words on a small register bus. The data word holds the output latch. The control word holds the pin-ownership byte and the direction byte.

For every pin the block picks an output level and an output enable. A pin owned by the peripheral takes both from the peripheral's own signals. A GPIO pin takes them from the output latch and the direction byte. Reads of the data word never return the latch. They return the pin levels, seen through a synchronizer. Software can write the first output value before it turns a pin into an output, so the pin never drives a stale value.

Top module: `shared_port_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the output latch, the direction byte and the ownership byte all become zero, and so do `pin_out`, `pin_oe` and `rdata`. Every pin therefore leaves reset as a GPIO input.
- R2: For a pin whose ownership bit is 0, `pin_out` follows the output latch bit and `pin_oe` follows the direction bit (1 = output).
- R3: A read of the data word (`sel`=0) returns the pin levels in `rdata[7:0]` through a two-flop synchronizer, never the latch. A level applied before edge k is returned by a read whose `rd_en` is sampled at edge k+2 or later. Reads at edges k and k+1 still return the previous level.
- R4: For a pin whose ownership bit is 1, `pin_out` and `pin_oe` take `per_out` and `per_oe`, and the latch and direction bits for that pin have no effect.
- R5: Ownership bits 7 and 2 do not exist. They read as 0 and ignore writes.
- R6: A value written to the output latch while the direction is 0 does not drive the pin. When the direction bit is later set, the pin drives that value from the first cycle its enable is high.
- R7: The control word (`sel`=1) holds ownership in bits [15:8] and direction in bits [7:0]. `be[1]` writes the ownership byte, `be[0]` writes the direction byte, and the two lanes are independent.
- R8: On the data word, `be[0]` writes the latch from `wdata[7:0]` and `be[1]` has no effect. The data word reads 0 in bits [15:8].
- R9: `pin_out` and `pin_oe` are registered. They reflect the register contents and the peripheral inputs as they stood at the previous clock edge.
- R10: `rdata` is registered. It loads on an edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | Word select: 0 data word, 1 control word |
| be | input | 2 | Byte-lane write enables (bit 1 = high byte) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output level to the pads |
| pin_oe | output | 8 | Output enable to the pads |
| per_out | input | 8 | Serial peripheral output levels |
| per_oe | input | 8 | Serial peripheral output enables |

## Verification
Two things can land in the same cycle: a register write or read, and a change on the pins or on the peripheral signals. A change of ownership can also meet a peripheral toggle on the same edge. The bench provokes both. It changes `pin_in` on the very cycle a data read is issued, and then keeps reading on the following edges, which exposes the synchronizer latency. It also moves `per_out` while the ownership byte is being rewritten. A behavioural model advances every clock, and each cycle it judges the result by comparing `pin_out`, `pin_oe` and `rdata`.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } spc_sel_e;
endpackage

// File: rtl/spc_regs.sv
module spc_regs #(
  parameter int unsigned PINS = 8,
  parameter logic [PINS-1:0] OWN_MASK = 8'b0111_1011
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        sel,
  input  logic [1:0]                  be,
  input  logic [spc_pkg::WORD_W-1:0]  wdata,
  output logic [PINS-1:0]             latch_q,
  output logic [PINS-1:0]             dir_q,
  output logic [PINS-1:0]             own_q
);
  localparam int unsigned HI = spc_pkg::LANE_W;

  logic wr_data, wr_dir, wr_own;
  assign wr_data = wr_en && (sel == spc_pkg::SEL_DATA) && be[0];
  assign wr_dir  = wr_en && (sel == spc_pkg::SEL_CTRL) && be[0];
  assign wr_own  = wr_en && (sel == spc_pkg::SEL_CTRL) && be[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      own_q   <= '0;
    end else begin
      if (wr_data) latch_q <= wdata[PINS-1:0];
      if (wr_dir)  dir_q   <= wdata[PINS-1:0];
      if (wr_own)  own_q   <= wdata[HI +: PINS] & OWN_MASK;
    end
  end

  // R5: unimplemented ownership bits never become set
  a_r5_own_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((own_q & ~OWN_MASK) == '0));
  // R8: high lane on the data word leaves the latch untouched
  a_r8_hi_lane_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == spc_pkg::SEL_DATA && !be[0]) |=> $stable(latch_q));
endmodule

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spc_pinmux.sv
module spc_pinmux #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] latch_q,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] own_q,
  input  logic [PINS-1:0] per_out,
  input  logic [PINS-1:0] per_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (own_q[i]) begin
        pin_out[i] <= per_out[i];
        pin_oe[i]  <= per_oe[i];
      end else begin
        pin_out[i] <= latch_q[i];
        pin_oe[i]  <= dir_q[i];
      end
    end

    // R4: a peripheral-owned pin follows the peripheral one cycle later
    a_r4_per_owns: assert property (@(posedge clk) disable iff (rst)
      own_q[i] |=> (pin_out[i] == $past(per_out[i]) && pin_oe[i] == $past(per_oe[i])));
    // R2: a GPIO pin follows latch and direction one cycle later
    a_r2_gpio_owns: assert property (@(posedge clk) disable iff (rst)
      !own_q[i] |=> (pin_out[i] == $past(latch_q[i]) && pin_oe[i] == $past(dir_q[i])));
  end
endmodule

// File: rtl/shared_port_ctrl.sv
module shared_port_ctrl #(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [PINS-1:0] OWN_MASK = 8'b0111_1011
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        sel,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  input  logic [7:0]  per_out,
  input  logic [7:0]  per_oe
);
  localparam int unsigned LW = spc_pkg::LANE_W;

  logic [PINS-1:0] latch_q, dir_q, own_q, pin_sync;
  logic [LW-1:0]   lvl_b, dir_b, own_b;

  spc_regs #(.PINS(PINS), .OWN_MASK(OWN_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .be(be), .wdata(wdata),
    .latch_q(latch_q), .dir_q(dir_q), .own_q(own_q)
  );

  spc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in[PINS-1:0]), .dout(pin_sync)
  );

  spc_pinmux #(.PINS(PINS)) u_mux (
    .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q), .own_q(own_q),
    .per_out(per_out[PINS-1:0]), .per_oe(per_oe[PINS-1:0]),
    .pin_out(pin_out[PINS-1:0]), .pin_oe(pin_oe[PINS-1:0])
  );

  if (PINS < LW) begin : g_pad
    assign pin_out[LW-1:PINS] = '0;
    assign pin_oe[LW-1:PINS]  = '0;
  end

  always_comb begin
    lvl_b = '0; dir_b = '0; own_b = '0;
    lvl_b[PINS-1:0] = pin_sync;
    dir_b[PINS-1:0] = dir_q;
    own_b[PINS-1:0] = own_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= (sel == spc_pkg::SEL_CTRL) ? {own_b, dir_b} : {{LW{1'b0}}, lvl_b};
  end

  // R1: outputs are quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rdata == '0));
  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R8: data word high byte reads zero
  a_r8_data_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == spc_pkg::SEL_DATA) |=> (rdata[15:8] == 8'h00));
  // R5: unimplemented ownership bits read zero
  a_r5_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == spc_pkg::SEL_CTRL) |=> (rdata[15] == 1'b0 && rdata[10] == 1'b0));
endmodule

// File: tb/sim_shared_port_ctrl.sv
`timescale 1ns/1ps
module sim_shared_port_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, sel = 0;
  logic [1:0] be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [7:0] pin_in = 0, pin_out, pin_oe, per_out = 0, per_oe = 0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shared_port_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .be(be),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .per_out(per_out), .per_oe(per_oe)
  );

  // behavioural reference model
  logic [7:0] m_lat = 0, m_dir = 0, m_own = 0, m_out = 0, m_oe = 0;
  logic [7:0] m_s1 = 0, m_s2 = 0;
  logic [15:0] m_rd = 0;

  always @(posedge clk) begin
    logic [7:0] n_out, n_oe;
    logic [15:0] n_rd;
    if (rst) begin
      m_lat = 0; m_dir = 0; m_own = 0; m_out = 0; m_oe = 0;
      m_s1 = 0; m_s2 = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        n_out[i] = m_own[i] ? per_out[i] : m_lat[i];
        n_oe[i]  = m_own[i] ? per_oe[i]  : m_dir[i];
      end
      n_rd = m_rd;
      if (rd_en) n_rd = sel ? {m_own, m_dir} : {8'h00, m_s2};
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (wr_en && !sel && be[0]) m_lat = wdata[7:0];
      if (wr_en && sel && be[0])  m_dir = wdata[7:0];
      if (wr_en && sel && be[1])  m_own = wdata[15:8] & 8'h7B;
      m_out = n_out; m_oe = n_oe; m_rd = n_rd;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R9 pin_out vs model", {8'h00, pin_out}, {8'h00, m_out});
      chk("R9 pin_oe vs model",  {8'h00, pin_oe},  {8'h00, m_oe});
      chk("R10 rdata vs model",  rdata, m_rd);
    end
  end

  task automatic wr(input logic s, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk); wr_en = 1; sel = s; be = b; wdata = d;
    @(negedge clk); wr_en = 0; be = 0;
  endtask

  task automatic rd(input logic s, output logic [15:0] v);
    @(negedge clk); rd_en = 1; sel = s;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, held;
    tick(3);
    rst = 0;
    // R1 reset state
    chk("R1 pin_oe", {8'h0, pin_oe}, 16'h0000);
    chk("R1 pin_out", {8'h0, pin_out}, 16'h0000);
    rd(1'b1, v); chk("R1 control word", v, 16'h0000);

    // R6 latch before direction
    wr(1'b0, 2'b01, 16'h00A5);
    tick(1);
    chk("R6 latched not driven oe", {8'h0, pin_oe}, 16'h0000);
    wr(1'b1, 2'b01, 16'h00FF);
    chk("R9 oe not yet", {8'h0, pin_oe}, 16'h0000);
    tick(1);
    chk("R6 first driven value", {8'h0, pin_out}, 16'h00A5);
    chk("R2 oe follows direction", {8'h0, pin_oe}, 16'h00FF);

    // R3 read returns pin levels, not latch
    @(negedge clk); pin_in = 8'h3C;
    tick(3);
    rd(1'b0, v); chk("R3 pin level read", v, 16'h003C);
    // R3 synchronizer latency: change pins on the read cycle itself
    @(negedge clk); pin_in = 8'hC3; rd_en = 1; sel = 0;
    @(negedge clk); chk("R3 edge k old level", rdata, 16'h003C);
    @(negedge clk); chk("R3 edge k+1 old level", rdata, 16'h003C);
    @(negedge clk); chk("R3 edge k+2 new level", rdata, 16'h00C3);
    rd_en = 0;

    // R7 / R5 byte lanes and unimplemented bits
    wr(1'b1, 2'b10, 16'hFF00);
    rd(1'b1, v); chk("R5 R7 high lane only", v, 16'h7BFF);
    wr(1'b1, 2'b01, 16'hEE12);
    rd(1'b1, v); chk("R7 low lane only", v, 16'h7B12);
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, v); chk("R7 both lanes", v, 16'h0000);

    // R4 peripheral ownership, with per_out moving during the write
    @(negedge clk); per_oe = 8'h0F; per_out = 8'h11;
    wr_en = 1; sel = 1; be = 2'b11; wdata = 16'h0FF0; per_out = 8'h5A;
    @(negedge clk); wr_en = 0; be = 0;
    tick(1);
    chk("R4 mixed pin_out", {8'h0, pin_out}, 16'h00AE);
    chk("R4 mixed pin_oe", {8'h0, pin_oe}, 16'h00FB);
    rd(1'b1, v); chk("R5 bit2 masked", v, 16'h0BF0);

    // R9 peripheral change seen after one edge
    @(negedge clk); per_out = 8'h00;
    @(negedge clk); chk("R9 per change one edge", {8'h0, pin_out}, 16'h00A4);

    // R8 high lane on data word ignored, high byte reads zero
    wr(1'b0, 2'b10, 16'hFF00);
    tick(1);
    chk("R8 latch unchanged", {8'h0, pin_out}, 16'h00A4);
    rd(1'b0, v); chk("R8 data high byte zero", {8'h0, v[15:8]}, 16'h0000);

    // R10 rdata holds without read
    held = rdata;
    @(negedge clk); pin_in = 8'h99;
    tick(4);
    chk("R10 rdata held", rdata, held);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    tick(2);
    rst = 0;
    chk("R1 mid-run pin_oe", {8'h0, pin_oe}, 16'h0000);
    rd(1'b1, v); chk("R1 mid-run control", v, 16'h0000);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wr_en   = ($urandom % 3) == 0;
      rd_en   = ($urandom % 2) == 0;
      sel     = $urandom % 2;
      be      = $urandom % 4;
      wdata   = $urandom;
      pin_in  = $urandom;
      per_out = $urandom;
      per_oe  = $urandom;
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    tick(2);
    finish_run();
  end
endmodule